// File: doc/BRIEF.md
# Smart Card Clock, Reset Supervisor and Character Receiver

This block produces the clock for a synchronous smart card from the system clock and supervises the card's reset sequence. It then deframes the card's answer characters from a single asynchronous receive line. A one-cycle `start` command starts the card clock. That moment is the time origin T0 of the sequence, and every later window is counted in rising edges of the card clock since T0.

After T0 the supervisor checks three things. The line must be idle (high) when a set number of card clock cycles have passed. The first falling edge of the answer must not come too early. It must also come before a timeout. Once the line idle check has passed, the receiver watches for a falling edge. It times each character from that edge and samples every bit at the middle of its period. The bit period is either the normal long period or a short alternative, chosen by `fast_mode`. Each character has a start bit, eight data bits sent low bit first, an even-parity bit and a stop bit.

The card clock has a 50% duty cycle. Its half period is a programmable whole number of system clocks. The integrating chip chooses `half_div` so that the card clock stays at 5 MHz or less. The receive line is not in phase with the card clock, so it passes through a two-stage synchronizer before any logic uses it.

Top module: `sc_rst_rx_seq`

## Requirements
- R1: After `start`, `card_clk` begins low and alternates, high for `half_div` system clocks and then low for `half_div` system clocks. A `half_div` of 0 is treated as 1. `card_clk` stays low from reset until the first `start`.
- R2: `start` (re)defines T0. In the following cycle the card clock counter and `idle_err`, `early_err`, `timeout_err` and `answer_started` are all cleared, and `seq_running` is high.
- R3: The synchronized line is sampled at card clock rising edge IDLE_CHK after T0. If it is low there, `idle_err` is set. `idle_err` stays set until the next `start`.
- R4: A falling edge on the line is taken as the start of the answer when at least IDLE_CHK rising edges have occurred since T0. If fewer than EARLY_LIM rising edges have occurred at that moment, `early_err` is set. Either way, `answer_started` is set.
- R5: If no answer has started when rising edge TIMEOUT_LIM occurs, `timeout_err` is set at that edge. A falling edge after the timeout does not set `answer_started`.
- R6: A character is 1 start bit (low), 8 data bits least significant bit first, 1 parity bit and 1 stop bit. The bit period is BIT_NORM card clocks when `fast_mode`=0 and BIT_FAST when `fast_mode`=1; `fast_mode` is read at the falling edge. Every bit is sampled at the middle of its period. After the stop bit is sampled, `rx_byte` holds the data and `rx_valid` pulses for one system clock.
- R7: `rx_perr` is 1, together with `rx_valid`, when the received parity bit differs from the XOR of the 8 data bits (even parity). Otherwise it is 0.
- R8: If the line is no longer low at the middle of the start bit, no character is produced and the receiver returns to waiting for the next falling edge.
- R9: During and after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse: start the card clock and define T0 |
| half_div | input | DIV_W | Card clock half period in system clocks |
| fast_mode | input | 1 | 1 selects the short bit period, 0 the normal one |
| rx | input | 1 | Asynchronous receive line from the card |
| card_clk | output | 1 | Clock driven to the card |
| seq_running | output | 1 | Card clock is running |
| answer_started | output | 1 | First answer falling edge has been seen |
| idle_err | output | 1 | Line was low at the idle check |
| early_err | output | 1 | Answer started before the early limit |
| timeout_err | output | 1 | No answer by the timeout limit |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_perr | output | 1 | Parity mismatch flag for the byte strobed |

## Verification
The bench builds the block with IDLE_CHK=20, EARLY_LIM=40 and TIMEOUT_LIM=400 in place of the production 200/400/40000. With these values each side of every window boundary can be reached within a few thousand system clocks. BIT_NORM keeps its production value of 372, and BIT_FAST is 16, so both bit periods are exercised at their real lengths. `half_div` is driven at 3 (a six-clock card period) for most tests and at 0 for the divider corner case.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic idle;
        logic early;
        logic timeout;
    } sup_flags_t;

    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 2;   // data + parity + stop after start

    // even parity: 1 when data plus parity holds an odd number of ones
    function automatic logic parity_bad(input logic [DATA_BITS:0] dp);
        return ^dp;
    endfunction

endpackage

// File: rtl/sc_clk_gen.sv
module sc_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] half_div,
    output logic             card_clk,
    output logic             running,
    output logic             cc_tick
);
    logic [DIV_W-1:0] hcnt;
    logic [DIV_W-1:0] div_q;
    logic             at_end;

    assign at_end  = (hcnt == div_q - DIV_W'(1));
    assign cc_tick = running && !start && at_end && !card_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            card_clk <= 1'b0;
            hcnt     <= '0;
            div_q    <= DIV_W'(1);
        end else if (start) begin
            running  <= 1'b1;
            card_clk <= 1'b0;
            hcnt     <= '0;
            div_q    <= (half_div == '0) ? DIV_W'(1) : half_div;
        end else if (running) begin
            if (at_end) begin
                hcnt     <= '0;
                card_clk <= ~card_clk;
            end else begin
                hcnt <= hcnt + DIV_W'(1);
            end
        end
    end

    // R1: the tick announces a rising edge on the next clock
    assert_tick_rises_R1: assert property (@(posedge clk) disable iff (rst)
        cc_tick |=> card_clk);

endmodule

// File: rtl/sc_rst_sup.sv
module sc_rst_sup
    import sc_seq_pkg::*;
#(
    parameter int IDLE_CHK    = 200,
    parameter int EARLY_LIM   = 400,
    parameter int TIMEOUT_LIM = 40000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       running,
    input  logic       cc_tick,
    input  logic       rx_s,
    input  logic       resp_begin,
    output logic       armed,
    output logic       resp_seen,
    output sup_flags_t flags
);
    localparam int CW = $clog2(TIMEOUT_LIM + 1);
    localparam logic [CW-1:0] IDLE_C  = CW'(IDLE_CHK);
    localparam logic [CW-1:0] EARLY_C = CW'(EARLY_LIM);
    localparam logic [CW-1:0] LIM_C   = CW'(TIMEOUT_LIM);

    logic [CW-1:0] cyc;
    logic [CW-1:0] cyc_nx;

    assign cyc_nx = cyc + CW'(1);
    assign armed  = running && (cyc >= IDLE_C);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cyc       <= '0;
            resp_seen <= 1'b0;
            flags     <= '0;
        end else begin
            if (cc_tick && cyc != LIM_C) begin
                cyc <= cyc_nx;
                if (cyc_nx == IDLE_C && !rx_s)
                    flags.idle <= 1'b1;
                if (cyc_nx == LIM_C && !resp_seen && !resp_begin)
                    flags.timeout <= 1'b1;
            end
            if (resp_begin && !resp_seen && !flags.timeout) begin
                resp_seen <= 1'b1;
                if (cyc < EARLY_C)
                    flags.early <= 1'b1;
            end
        end
    end

    // R2: a start clears every flag
    assert_restart_clear_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (flags == '0 && !resp_seen));
    // R3: idle error is sticky until restart
    assert_idle_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (flags.idle && !start) |=> flags.idle);
    // R4: early error only when the answer began inside the early window
    assert_early_window_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.early) |-> ($past(cyc) < EARLY_C));
    // R5: timeout and an answer exclude each other
    assert_timeout_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(flags.timeout && resp_seen));

endmodule

// File: rtl/sc_rx_deframe.sv
module sc_rx_deframe
    import sc_seq_pkg::*;
#(
    parameter int BIT_NORM = 372,
    parameter int BIT_FAST = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 armed,
    input  logic                 cc_tick,
    input  logic                 fast_mode,
    input  logic                 rx_s,
    output logic                 resp_begin,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 rx_perr
);
    localparam int TW = $clog2(BIT_NORM + 1);
    localparam int BW = $clog2(FRAME_BITS + 1);

    rx_state_e          st;
    logic               rx_prev;
    logic [TW-1:0]      tcnt;
    logic [TW-1:0]      per_q;
    logic [TW-1:0]      tcnt_nx;
    logic [BW-1:0]      bitn;
    logic [DATA_BITS:0] shreg;

    assign tcnt_nx    = tcnt + TW'(1);
    assign resp_begin = (st == RX_IDLE) && armed && rx_prev && !rx_s;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            st       <= RX_IDLE;
            rx_prev  <= 1'b1;
            tcnt     <= '0;
            per_q    <= TW'(BIT_NORM);
            bitn     <= '0;
            shreg    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            rx_perr  <= 1'b0;
        end else begin
            rx_prev  <= rx_s;
            rx_valid <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (resp_begin) begin
                        st    <= RX_START;
                        tcnt  <= '0;
                        per_q <= fast_mode ? TW'(BIT_FAST) : TW'(BIT_NORM);
                    end
                end
                RX_START: begin
                    if (cc_tick) begin
                        if (tcnt_nx == (per_q >> 1)) begin
                            tcnt <= '0;
                            bitn <= '0;
                            st   <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt_nx;
                        end
                    end
                end
                RX_DATA: begin
                    if (cc_tick) begin
                        if (tcnt_nx == per_q) begin
                            tcnt <= '0;
                            if (bitn == BW'(FRAME_BITS - 1)) begin
                                st       <= RX_IDLE;
                                rx_valid <= 1'b1;
                                rx_byte  <= shreg[DATA_BITS-1:0];
                                rx_perr  <= parity_bad(shreg);
                            end else begin
                                shreg <= {rx_s, shreg[DATA_BITS:1]};
                                bitn  <= bitn + BW'(1);
                            end
                        end else begin
                            tcnt <= tcnt_nx;
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // R6: byte strobe lasts a single system clock
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
    // R8: the start bit is judged only on a card clock edge
    assert_start_mid_tick_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == RX_START && st != RX_START && !$past(start)) |-> $past(cc_tick));

endmodule

// File: rtl/sc_rst_rx_seq.sv
module sc_rst_rx_seq
    import sc_seq_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int IDLE_CHK    = 200,
    parameter int EARLY_LIM   = 400,
    parameter int TIMEOUT_LIM = 40000,
    parameter int BIT_NORM    = 372,
    parameter int BIT_FAST    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DIV_W-1:0] half_div,
    input  logic             fast_mode,
    input  logic             rx,
    output logic             card_clk,
    output logic             seq_running,
    output logic             answer_started,
    output logic             idle_err,
    output logic             early_err,
    output logic             timeout_err,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    output logic             rx_perr
);
    logic       rx_m, rx_s;
    logic       cc_tick, armed, resp_begin;
    sup_flags_t flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rx;
            rx_s <= rx_m;
        end
    end

    sc_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst(rst), .start(start), .half_div(half_div),
        .card_clk(card_clk), .running(seq_running), .cc_tick(cc_tick)
    );

    sc_rst_sup #(.IDLE_CHK(IDLE_CHK), .EARLY_LIM(EARLY_LIM), .TIMEOUT_LIM(TIMEOUT_LIM)) u_sup (
        .clk(clk), .rst(rst), .start(start), .running(seq_running),
        .cc_tick(cc_tick), .rx_s(rx_s), .resp_begin(resp_begin),
        .armed(armed), .resp_seen(answer_started), .flags(flags)
    );

    sc_rx_deframe #(.BIT_NORM(BIT_NORM), .BIT_FAST(BIT_FAST)) u_rx (
        .clk(clk), .rst(rst), .start(start), .armed(armed), .cc_tick(cc_tick),
        .fast_mode(fast_mode), .rx_s(rx_s), .resp_begin(resp_begin),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_perr(rx_perr)
    );

    assign idle_err    = flags.idle;
    assign early_err   = flags.early;
    assign timeout_err = flags.timeout;

endmodule

// File: tb/sc_rst_rx_seq_tb.sv
module sc_rst_rx_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] half_div = 8'd3;
    logic       fast_mode = 1'b1;
    logic       rx = 1'b1;
    logic       card_clk, seq_running, answer_started;
    logic       idle_err, early_err, timeout_err;
    logic [7:0] rx_byte;
    logic       rx_valid, rx_perr;

    int errors = 0;
    int checks = 0;
    int got_n = 0;
    logic [7:0] got_byte = '0;
    logic       got_perr = 1'b0;
    bit         done = 0;

    always #4 clk = ~clk;   // 125 MHz

    sc_rst_rx_seq #(.DIV_W(8), .IDLE_CHK(20), .EARLY_LIM(40), .TIMEOUT_LIM(400),
                    .BIT_NORM(372), .BIT_FAST(16)) u_dut (
        .clk(clk), .rst(rst), .start(start), .half_div(half_div),
        .fast_mode(fast_mode), .rx(rx), .card_clk(card_clk),
        .seq_running(seq_running), .answer_started(answer_started),
        .idle_err(idle_err), .early_err(early_err), .timeout_err(timeout_err),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_perr(rx_perr)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            got_n    <= got_n + 1;
            got_byte <= rx_byte;
            got_perr <= rx_perr;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_rise(input int n);
        repeat (n) @(posedge card_clk);
        #1;
    endtask

    task automatic send_char(input logic [7:0] b, input logic par_ok, input int per);
        rx = 1'b0;
        wait_rise(per);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            wait_rise(per);
        end
        rx = par_ok ? ^b : ~^b;
        wait_rise(per);
        rx = 1'b1;
        wait_rise(per + 2);
    endtask

    task automatic t_reset();
        chk("R9 card_clk", card_clk, 0);
        chk("R9 running", seq_running, 0);
        chk("R9 flags", {idle_err, early_err, timeout_err, answer_started}, 0);
        chk("R9 valid", {rx_valid, rx_perr, rx_byte}, 0);
    endtask

    task automatic t_clock(input logic [7:0] hd, input int exp_half);
        int n;
        half_div = hd;
        pulse_start();
        chk("R2 running", seq_running, 1);
        @(posedge card_clk); #1;
        n = 0;
        while (card_clk) begin @(posedge clk); #1; n++; end
        chk("R1 high length", n, exp_half);
        n = 0;
        while (!card_clk) begin @(posedge clk); #1; n++; end
        chk("R1 low length", n, exp_half);
        half_div = 8'd3;
    endtask

    task automatic t_idle();
        rx = 1'b0;
        pulse_start();
        wait_rise(19);
        rx = 1'b1;
        wait_rise(2);
        chk("R3 line high in time", idle_err, 0);
        rx = 1'b0;
        pulse_start();
        wait_rise(20);
        rx = 1'b1;
        wait_rise(1);
        chk("R3 line low at check", idle_err, 1);
        wait_rise(5);
        chk("R3 sticky", idle_err, 1);
        pulse_start();
        chk("R2 restart clears", {idle_err, early_err, timeout_err, answer_started}, 0);
    endtask

    task automatic t_early_glitch();
        int n0;
        fast_mode = 1'b1;
        rx = 1'b1;
        pulse_start();
        wait_rise(39);
        rx = 1'b0;
        wait_rise(3);
        rx = 1'b1;
        chk("R4 early flagged", early_err, 1);
        chk("R4 answer seen", answer_started, 1);
        n0 = got_n;
        wait_rise(40);
        chk("R8 glitch gives no byte", got_n, n0);
        send_char(8'h5A, 1'b1, 16);
        chk("R8 recovers count", got_n, n0 + 1);
        chk("R8 recovers byte", got_byte, 8'h5A);
    endtask

    task automatic t_ontime();
        int n0;
        fast_mode = 1'b1;
        pulse_start();
        wait_rise(40);
        n0 = got_n;
        send_char(8'hA5, 1'b1, 16);
        chk("R4 boundary not early", early_err, 0);
        chk("R4 answer seen", answer_started, 1);
        chk("R6 fast count", got_n, n0 + 1);
        chk("R6 fast byte", got_byte, 8'hA5);
        chk("R7 good parity", got_perr, 0);
        wait_rise(200);
        chk("R5 no timeout after answer", timeout_err, 0);
    endtask

    task automatic t_timeout();
        rx = 1'b1;
        pulse_start();
        wait_rise(399);
        chk("R5 before limit", timeout_err, 0);
        wait_rise(1);
        chk("R5 at limit", timeout_err, 1);
        rx = 1'b0;
        wait_rise(2);
        rx = 1'b1;
        wait_rise(2);
        chk("R5 late edge ignored", answer_started, 0);
    endtask

    task automatic t_parity();
        int n0;
        fast_mode = 1'b1;
        pulse_start();
        wait_rise(40);
        n0 = got_n;
        send_char(8'h3C, 1'b0, 16);
        chk("R7 count", got_n, n0 + 1);
        chk("R7 byte", got_byte, 8'h3C);
        chk("R7 bad parity", got_perr, 1);
    endtask

    task automatic t_normal();
        int n0;
        fast_mode = 1'b0;
        pulse_start();
        wait_rise(40);
        n0 = got_n;
        send_char(8'h3B, 1'b1, 372);
        chk("R6 normal count", got_n, n0 + 1);
        chk("R6 normal byte", got_byte, 8'h3B);
        chk("R7 normal parity", got_perr, 0);
        fast_mode = 1'b1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk) rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_clock(8'd3, 3);
        t_clock(8'd0, 1);
        t_idle();
        t_early_glitch();
        t_ontime();
        t_timeout();
        t_parity();
        t_normal();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule